// File: doc/BRIEF.md
# EDO DRAM Output Path Controller

This block is a clock-sampled, cycle-level model of the logic that governs the data pins of an extended-data-out DRAM. It watches four active-low strobes (row strobe, column strobe, write enable, output enable) on a system clock. From them it works out what kind of memory cycle is running, when to fetch a word from the array, when to capture that word in the output latch, and whether the output driver is on or in high impedance. The array itself is abstract: the block raises a one-cycle read request and takes the word from the array data port in the same cycle.

The defining trait is that read data is not dropped when the column strobe returns high. The latch keeps its word and the driver stays on, so page-mode column cycles can be as short as the access time. The output is released only after both strobes have been high for a fixed number of clocks, counted from whichever of the two rose last. A strobe that falls during that count cancels it, and the count starts again in full at the next moment both strobes are high. Output enable and write enable gate the driver but never touch the latch contents.

The array port has no back-pressure. The array is taken to be always ready, and `arr_rd_data` must be valid in the same cycle as `arr_rd_req`. The strobes are plain level inputs and have no handshake.

Top module: `edo_out_ctrl`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released, `drv_en` is 0, `dout` is 0 and `arr_rd_req` is 0.
- R2: A memory cycle starts when the row strobe falls while the column strobe is high. Within that cycle, a column strobe fall with write enable high drives `arr_rd_req` to 1 in that same clock. At that edge `dout` takes `arr_rd_data`, and `drv_en` becomes 1 when output enable is low.
- R3: The latch keeps its word and the driver stays on after the column strobe rises. A later column strobe fall in the same row, with write enable high, reads and drives a new word (page mode). `dout` changes only at an edge where `arr_rd_req` is 1.
- R4: Suppose both strobes are first seen high at edge k, so the later rising edge is sampled at k. Then `drv_en` stays 1 after edges k to k+TOFF_CYC-1 and is 0 after edge k+TOFF_CYC. A row strobe rise leaves `dout` unchanged.
- R5: If either strobe falls before the turn-off count expires, the count is cancelled. It restarts from TOFF_CYC at the next edge where both strobes are high again.
- R6: A column strobe fall while the row strobe is high produces no read request and changes neither `dout` nor `drv_en`.
- R7: Output enable high turns `drv_en` off after the next edge and leaves `dout` unchanged. When output enable goes low again, the same word is driven again.
- R8: Write enable low while the column strobe is low turns `drv_en` off after the next edge. With the column strobe high, write enable has no effect on the driver.
- R9: An early write (column strobe fall with write enable low) produces no read request and empties the latch. The output stays in high impedance even after write enable returns high.
- R10: A row-only refresh (row strobe low, column strobe never falls) produces no read request and leaves the output in high impedance.
- R11: A refresh in which the column strobe falls before the row strobe produces no read request and keeps the driver state and `dout` exactly as they were before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| arr_rd_data | input | DATA_W | Word returned by the array in the cycle of the request |
| arr_rd_req | output | 1 | One-cycle array read request (combinational) |
| dout | output | DATA_W | Output latch contents |
| drv_en | output | 1 | Output driver enable; 0 means high impedance |

## Verification
If the cycle-kind state goes wrong, it shows up at the ports in the same clock. A column fall after a refresh-style row fall would raise `arr_rd_req`, or a real read would not raise it. If the output latch flag goes wrong, `drv_en` takes the wrong value after the very next edge. This is visible most clearly after an early write, or across the end of a cycle. A miscounting turn-off timer shows up as `drv_en` falling one or more edges too early or too late after the later strobe rise, and the cancel-and-restart sequences expose it by shifting that point.

// File: rtl/edo_pkg.sv
package edo_pkg;

  // One sampled view of the strobes: levels plus edges against the previous sample
  typedef struct packed {
    logic ras_lo;
    logic cas_lo;
    logic we_lo;
    logic oe_hi;
    logic ras_fall;
    logic ras_rise;
    logic cas_fall;
    logic cas_rise;
  } strobe_ev_t;

  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_ACCESS = 2'd1,
    CYC_CBR    = 2'd2
  } cyc_kind_t;

endpackage

// File: rtl/edo_strobe_edge.sv
module edo_strobe_edge
  import edo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       oe_n,
  output strobe_ev_t ev
);

  logic ras_q;
  logic cas_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
    end
  end

  always_comb begin
    ev.ras_lo   = ~ras_n;
    ev.cas_lo   = ~cas_n;
    ev.we_lo    = ~we_n;
    ev.oe_hi    = oe_n;
    ev.ras_fall = ras_q & ~ras_n;
    ev.ras_rise = ~ras_q & ras_n;
    ev.cas_fall = cas_q & ~cas_n;
    ev.cas_rise = ~cas_q & cas_n;
  end

endmodule

// File: rtl/edo_cycle_track.sv
module edo_cycle_track
  import edo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_ev_t ev,
  output logic       access_now
);

  cyc_kind_t kind_q;
  cyc_kind_t kind_nx;

  always_comb begin
    kind_nx = kind_q;
    if (!ev.ras_lo) begin
      kind_nx = CYC_IDLE;
    end else if (ev.ras_fall) begin
      // column already low when the row falls: refresh, no array access
      kind_nx = ev.cas_lo ? CYC_CBR : CYC_ACCESS;
    end
  end

  assign access_now = (kind_nx == CYC_ACCESS);

  always_ff @(posedge clk) begin
    if (!rst_n) kind_q <= CYC_IDLE;
    else        kind_q <= kind_nx;
  end

endmodule

// File: rtl/edo_hz_timer.sv
module edo_hz_timer
  import edo_pkg::*;
#(
  parameter int TOFF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_ev_t ev,
  output logic       expire
);

  localparam int CNT_W = $clog2(TOFF_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(TOFF_CYC);
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             both_hi;
  logic             late_rise;

  assign both_hi   = ~ev.ras_lo & ~ev.cas_lo;
  assign late_rise = ev.ras_rise | ev.cas_rise;
  assign expire    = both_hi & ~late_rise & (cnt_q == ONE_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!both_hi) begin
      cnt_q <= '0;
    end else if (late_rise) begin
      cnt_q <= LOAD_V;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE_V;
    end
  end

endmodule

// File: rtl/edo_out_ctrl.sv
module edo_out_ctrl
  import edo_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TOFF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic              arr_rd_req,
  output logic [DATA_W-1:0] dout,
  output logic              drv_en
);

  strobe_ev_t ev;
  logic       access_now;
  logic       hz_expire;
  logic       col_start;
  logic       early_wr;
  logic       held_q;
  logic       held_nx;
  logic       drv_nx;

  edo_strobe_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .ev    (ev)
  );

  edo_cycle_track u_cyc (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .access_now (access_now)
  );

  edo_hz_timer #(.TOFF_CYC(TOFF_CYC)) u_hz (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .expire (hz_expire)
  );

  assign col_start  = access_now & ev.cas_fall;
  assign arr_rd_req = col_start & ~ev.we_lo;
  assign early_wr   = col_start & ev.we_lo;

  always_comb begin
    held_nx = held_q;
    if (arr_rd_req)     held_nx = 1'b1;
    else if (early_wr)  held_nx = 1'b0;
    else if (hz_expire) held_nx = 1'b0;
    drv_nx = held_nx & ~ev.oe_hi & ~(ev.we_lo & ev.cas_lo);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      dout   <= '0;
      drv_en <= 1'b0;
    end else begin
      held_q <= held_nx;
      drv_en <= drv_nx;
      if (arr_rd_req) dout <= arr_rd_data;
    end
  end

endmodule

// File: rtl/edo_out_ctrl_chk.sv
module edo_out_ctrl_chk #(
  parameter int DATA_W   = 8,
  parameter int TOFF_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] arr_rd_data,
  input logic              arr_rd_req,
  input logic [DATA_W-1:0] dout,
  input logic              drv_en
);

  localparam int RUN_W = $clog2(TOFF_CYC + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(TOFF_CYC + 1);

  logic [RUN_W-1:0] hi_run;

  // consecutive samples with both strobes high, saturating
  always_ff @(posedge clk) begin
    if (!rst_n)                hi_run <= '0;
    else if (!(ras_n && cas_n)) hi_run <= '0;
    else if (hi_run != RUN_MAX) hi_run <= hi_run + 1'b1;
  end

  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_req |-> (!ras_n && !cas_n && we_n));

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_rd_req |=> $stable(dout));

  assert_turnoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_run == RUN_MAX) |-> !drv_en);

  assert_cas_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |-> !arr_rd_req);

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !drv_en);

  assert_we_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !cas_n) |=> !drv_en);

  assert_early_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !cas_n) |-> !arr_rd_req);

endmodule

bind edo_out_ctrl edo_out_ctrl_chk #(.DATA_W(DATA_W), .TOFF_CYC(TOFF_CYC)) u_chk (.*);

// File: tb/sim_edo_out_ctrl.sv
`timescale 1ns/1ps
module sim_edo_out_ctrl;
  localparam int DW = 8;
  localparam int T  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] arr_rd_data = '0;
  logic          arr_rd_req;
  logic [DW-1:0] dout;
  logic          drv_en;

  always #4 clk = ~clk;

  edo_out_ctrl #(.DATA_W(DW), .TOFF_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .arr_rd_data(arr_rd_data), .arr_rd_req(arr_rd_req),
    .dout(dout), .drv_en(drv_en)
  );

  typedef struct {
    logic          drv;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of strobes, check the request now, queue the post-edge result
  task automatic step(input logic r, input logic c, input logic w, input logic o,
                      input logic [DW-1:0] d, input logic e_req, input logic e_drv,
                      input logic [DW-1:0] e_dout, input string tag);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; arr_rd_data = d;
    #1;
    cmp(tag, "arr_rd_req", 32'(arr_rd_req), 32'(e_req));
    sb.push_back('{e_drv, e_dout, tag});
  endtask

  // both strobes high: T edges still driving, then released
  task automatic release_hz(input logic [DW-1:0] e_dout, input string tag);
    for (int i = 0; i < T; i++) step(1, 1, 1, 0, 8'h00, 0, 1, e_dout, tag);
    step(1, 1, 1, 0, 8'h00, 0, 0, e_dout, tag);
  endtask

  // monitor: compare each queued item just after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.tag, "drv_en", 32'(drv_en), 32'(e.drv));
        cmp(e.tag, "dout", 32'(dout), 32'(e.data));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    cmp("R1", "drv_en", 32'(drv_en), 0);
    cmp("R1", "dout", 32'(dout), 0);
    cmp("R1", "arr_rd_req", 32'(arr_rd_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 1, 1, 0, 8'h00, 0, 0, 8'h00, "R1");

    // R2 read, R3 hold after column rise and page read, R4 turn-off
    step(0, 1, 1, 0, 8'h00, 0, 0, 8'h00, "R2");
    step(0, 0, 1, 0, 8'hA5, 1, 1, 8'hA5, "R2");
    step(0, 1, 1, 0, 8'h00, 0, 1, 8'hA5, "R3");
    step(0, 0, 1, 0, 8'h3C, 1, 1, 8'h3C, "R3");
    step(0, 1, 1, 0, 8'h00, 0, 1, 8'h3C, "R3");
    release_hz(8'h3C, "R4");

    // R5: column fall cancels the count, restart from full on the rise
    step(0, 1, 1, 0, 8'h00, 0, 0, 8'h3C, "R5");
    step(0, 0, 1, 0, 8'h5A, 1, 1, 8'h5A, "R5");
    step(1, 1, 1, 0, 8'h00, 0, 1, 8'h5A, "R5");
    step(1, 1, 1, 0, 8'h00, 0, 1, 8'h5A, "R5");
    step(1, 0, 1, 0, 8'hEE, 0, 1, 8'h5A, "R6");
    release_hz(8'h5A, "R5");

    // R7 output enable gating
    step(0, 1, 1, 0, 8'h00, 0, 0, 8'h5A, "R7");
    step(0, 0, 1, 0, 8'h81, 1, 1, 8'h81, "R7");
    step(0, 0, 1, 1, 8'h00, 0, 0, 8'h81, "R7");
    step(0, 0, 1, 0, 8'h00, 0, 1, 8'h81, "R7");
    // R8 write enable gating (late write)
    step(0, 0, 0, 0, 8'h00, 0, 0, 8'h81, "R8");
    step(0, 0, 1, 0, 8'h00, 0, 1, 8'h81, "R8");
    step(0, 1, 0, 0, 8'h00, 0, 1, 8'h81, "R8");
    release_hz(8'h81, "R8");

    // R9 early write empties the latch
    step(0, 1, 1, 0, 8'h00, 0, 0, 8'h81, "R9");
    step(0, 0, 1, 0, 8'h77, 1, 1, 8'h77, "R9");
    step(0, 1, 1, 0, 8'h00, 0, 1, 8'h77, "R9");
    step(0, 0, 0, 0, 8'h99, 0, 0, 8'h77, "R9");
    step(0, 1, 1, 0, 8'h00, 0, 0, 8'h77, "R9");
    step(1, 1, 1, 0, 8'h00, 0, 0, 8'h77, "R9");

    // R10 row-only refresh
    step(0, 1, 1, 0, 8'hFF, 0, 0, 8'h77, "R10");
    step(0, 1, 1, 0, 8'hFF, 0, 0, 8'h77, "R10");
    step(1, 1, 1, 0, 8'h00, 0, 0, 8'h77, "R10");

    // R11 column-before-row refresh keeps the previous output state
    step(0, 1, 1, 0, 8'h00, 0, 0, 8'h77, "R11");
    step(0, 0, 1, 0, 8'h42, 1, 1, 8'h42, "R11");
    step(0, 1, 1, 0, 8'h00, 0, 1, 8'h42, "R11");
    step(1, 1, 1, 0, 8'h00, 0, 1, 8'h42, "R11");
    step(1, 0, 1, 0, 8'hC3, 0, 1, 8'h42, "R11");
    step(0, 0, 1, 0, 8'hC3, 0, 1, 8'h42, "R11");
    step(0, 0, 1, 0, 8'hC3, 0, 1, 8'h42, "R11");
    step(1, 0, 1, 0, 8'h00, 0, 1, 8'h42, "R11");
    release_hz(8'h42, "R11");
    step(1, 0, 1, 0, 8'h00, 0, 0, 8'h42, "R11");
    step(0, 0, 1, 0, 8'h11, 0, 0, 8'h42, "R11");
    step(1, 1, 1, 0, 8'h00, 0, 0, 8'h42, "R11");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule